// File: doc/BRIEF.md
# SPI Burst Exchange Master

This block is an SPI master that runs counted bursts of full-duplex byte exchanges. Software loads a transmit FIFO through a byte-wide push port, programs a burst length and a count of bytes to take from that FIFO, and sets a start bit in the control word. The block then shifts the bytes out on MOSI. At the same time it captures MISO into a receive FIFO, which software empties through a byte-wide pop port. The start bit clears itself when the burst ends, so software polls that bit to detect completion.

The serial clock advances one half-period on each cycle where the external `sclk_tick` enable is high. Both clock polarities and both phases are supported. Bytes go out most-significant bit first. Four chip-select lines are available. Software can drive them by hand from a level bit, or the block can assert the selected line for the length of a burst. An optional pause mode stops the serial clock while the transmit FIFO is empty and resumes when data arrives.

The register window is four words, picked by `reg_addr`: 0 is control, 1 is burst length, 2 is transmit count and 3 is FIFO status. Reads return the addressed word one cycle after the address is presented.

Top module: `spi_burst_master`

## Requirements
- R1: After reset the control word reads 0, the FIFO status reads 0, `sclk` is 0 and every chip-select line is 0.
- R2: FIFO status (word 3) gives the receive occupancy in bits 6:0 and the transmit occupancy in bits 22:16. Each FIFO holds 64 bytes, and pushes into a full FIFO are dropped.
- R3: Data is shifted MSB first. `sclk` idles at control bit 3 (polarity). With control bit 2 (phase) clear, MOSI is valid before the first edge and is sampled on each edge that leaves the idle level. With bit 2 set, MOSI changes on the edge that leaves idle and is sampled on the edge that returns to it.
- R4: A control write with bit 10 set, bit 0 (enable) set and bit 1 (master) set starts a burst of exactly burst-length (word 1, 24 bits) bytes. Bit 10 reads 1 until the last byte completes and then reads 0.
- R5: Each byte received on MISO is pushed into the receive FIFO. A pop returns the bytes in arrival order on `rx_data` in the cycle after `rx_pop`.
- R6: Only the first transmit-count bytes (word 2, 24 bits) of a burst are taken from the transmit FIFO. The remaining bytes of the burst are sent as 0x00.
- R7: With control bit 18 clear, a byte that is due from an empty transmit FIFO is sent as 0x00 and nothing is popped.
- R8: With control bit 18 set, the engine holds `sclk` at its idle level while the transmit FIFO is empty and a byte is due. Bit 10 stays 1 during the wait, and the burst resumes after a push.
- R9: Writing 1 to control bit 8 empties the transmit FIFO, and writing 1 to control bit 9 empties the receive FIFO.
- R10: Control bits 13:12 select one chip-select line. When bit 16 (manual) is set, the selected line follows bit 17 and every other line sits at its inactive level. The inactive level is 1 when bit 4 is set and 0 otherwise.
- R11: When bit 16 is clear, the selected line is driven to its active level (the inverse of bit 4) while a burst runs. At most one line is ever away from the inactive level.
- R12: Clearing bit 0 aborts a running burst, returns `sclk` to the idle level and clears bit 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the addressed word |
| tx_push | input | 1 | Push `tx_data` into the transmit FIFO |
| tx_data | input | 8 | Transmit byte |
| rx_pop | input | 1 | Pop the receive FIFO |
| rx_data | output | 8 | Popped receive byte, valid the cycle after `rx_pop` |
| sclk_tick | input | 1 | Half-period enable for the serial clock |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Chip-select lines |

## Verification
The same five-byte burst runs in all four polarity/phase combinations. A monitor samples MOSI on the edge the mode defines and compares each byte, MSB first, with the pushed value. MISO is tied to inverted MOSI, so receive data differs from transmit data, and a wrong sampling edge or bit order shows up in both directions. Further bursts use a transmit count below the burst length, a transmit FIFO that runs dry with the pause bit clear and then set, and a disable in mid-burst. These separate the zero-fill, underflow, stall and abort paths. Separate patterns fill the FIFO past its depth, flush each FIFO, and move the chip-select level by hand.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;
  // control word bit positions
  localparam int CB_EN     = 0;
  localparam int CB_MASTER = 1;
  localparam int CB_CPHA   = 2;
  localparam int CB_CPOL   = 3;
  localparam int CB_CSLOW  = 4;
  localparam int CB_TXRST  = 8;
  localparam int CB_RXRST  = 9;
  localparam int CB_GO     = 10;
  localparam int CB_CSSEL  = 12;
  localparam int CB_CSMAN  = 16;
  localparam int CB_CSLVL  = 17;
  localparam int CB_PAUSE  = 18;
  localparam int RX_CNT_LSB = 0;
  localparam int TX_CNT_LSB = 16;

  typedef enum logic [1:0] {
    W_CTRL  = 2'd0,
    W_BURST = 2'd1,
    W_XMIT  = 2'd2,
    W_FSTAT = 2'd3
  } reg_word_e;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_LOAD = 2'd1,
    ENG_RUN  = 2'd2
  } eng_state_e;
endpackage

// File: rtl/spi_bm_fifo.sv
module spi_bm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_bm_engine.sv
module spi_bm_engine
  import spi_bm_pkg::*;
#(
  parameter int CNTW = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            cpol,
  input  logic            cpha,
  input  logic            pause,
  input  logic            start,
  input  logic [CNTW-1:0] burst_len,
  input  logic [CNTW-1:0] xmit_len,
  input  logic            tick,
  input  logic            tx_empty,
  input  logic [7:0]      tx_head,
  input  logic            miso,
  output logic            busy,
  output logic            done,
  output logic            tx_pop,
  output logic            rx_push,
  output logic [7:0]      rx_byte,
  output logic            sclk,
  output logic            mosi
);
  eng_state_e      st;
  logic [CNTW-1:0] remain, sent;
  logic [3:0]      half;
  logic [7:0]      tsh;
  logic [6:0]      rsh;
  logic            want_tx, ld_go, lead, samp, shft;
  logic [7:0]      ld_dat;

  assign busy = (st != ENG_IDLE);

  always_comb begin
    want_tx = (sent < xmit_len);
    ld_go   = want_tx ? (!tx_empty || !pause) : 1'b1;
    ld_dat  = (want_tx && !tx_empty) ? tx_head : 8'h00;
    lead    = ~half[0];
    samp    = lead ^ cpha;
    shft    = cpha ? lead : (~lead && (half != 4'hF));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ENG_IDLE;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      half    <= '0;
      tsh     <= '0;
      rsh     <= '0;
      remain  <= '0;
      sent    <= '0;
      tx_pop  <= 1'b0;
      rx_push <= 1'b0;
      rx_byte <= '0;
      done    <= 1'b0;
    end else begin
      tx_pop  <= 1'b0;
      rx_push <= 1'b0;
      done    <= 1'b0;
      if (!en) begin
        st   <= ENG_IDLE;
        sclk <= cpol;
      end else begin
        case (st)
          ENG_IDLE: begin
            sclk <= cpol;
            if (start) begin
              if (burst_len == '0) begin
                done <= 1'b1;
              end else begin
                remain <= burst_len;
                sent   <= '0;
                st     <= ENG_LOAD;
              end
            end
          end
          ENG_LOAD: begin
            if (ld_go) begin
              tx_pop <= want_tx && !tx_empty;
              half   <= '0;
              st     <= ENG_RUN;
              if (!cpha) begin
                mosi <= ld_dat[7];
                tsh  <= {ld_dat[6:0], 1'b0};
              end else begin
                tsh  <= ld_dat;
              end
            end
          end
          ENG_RUN: begin
            if (tick) begin
              sclk <= ~sclk;
              half <= half + 4'd1;
              if (samp) begin
                rsh <= {rsh[5:0], miso};
                if (half[3:1] == 3'd7) begin
                  rx_push <= 1'b1;
                  rx_byte <= {rsh, miso};
                end
              end
              if (shft) begin
                mosi <= tsh[7];
                tsh  <= {tsh[6:0], 1'b0};
              end
              if (half == 4'hF) begin
                sent   <= sent + CNTW'(1);
                remain <= remain - CNTW'(1);
                if (remain == CNTW'(1)) begin
                  st   <= ENG_IDLE;
                  done <= 1'b1;
                end else begin
                  st <= ENG_LOAD;
                end
              end
            end
          end
          default: st <= ENG_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_bm_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNTW  = 24,
  parameter int NCS   = 4,
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int CSW = $clog2(NCS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic [1:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           tx_push,
  input  logic [7:0]     tx_data,
  input  logic           rx_pop,
  output logic [7:0]     rx_data,
  input  logic           sclk_tick,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] spi_cs
);
  logic            en_q, master_q, cpha_q, cpol_q, cs_low_q, cs_man_q, cs_lvl_q, pause_q;
  logic [CSW-1:0]  cs_sel_q;
  logic            go_q, start_q;
  logic [CNTW-1:0] burst_q, xmit_q;
  logic            run_en, ctl_wr, tx_flush, rx_flush;
  logic            busy, done, tx_pop, rx_push, tx_empty, rx_empty;
  logic [7:0]      tx_head, rx_head, rx_byte;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic [31:0]     rd_nxt;
  logic [NCS-1:0]  cs_nxt;

  assign run_en   = en_q && master_q;
  assign ctl_wr   = reg_wr && (reg_addr == W_CTRL);
  assign tx_flush = ctl_wr && reg_wdata[CB_TXRST];
  assign rx_flush = ctl_wr && reg_wdata[CB_RXRST];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; master_q <= 1'b0; cpha_q <= 1'b0; cpol_q <= 1'b0;
      cs_low_q <= 1'b0; cs_man_q <= 1'b0; cs_lvl_q <= 1'b0; pause_q <= 1'b0;
      cs_sel_q <= '0;
      go_q <= 1'b0; start_q <= 1'b0;
      burst_q <= '0; xmit_q <= '0;
    end else begin
      start_q <= 1'b0;
      if (ctl_wr) begin
        en_q     <= reg_wdata[CB_EN];
        master_q <= reg_wdata[CB_MASTER];
        cpha_q   <= reg_wdata[CB_CPHA];
        cpol_q   <= reg_wdata[CB_CPOL];
        cs_low_q <= reg_wdata[CB_CSLOW];
        cs_sel_q <= reg_wdata[CB_CSSEL +: CSW];
        cs_man_q <= reg_wdata[CB_CSMAN];
        cs_lvl_q <= reg_wdata[CB_CSLVL];
        pause_q  <= reg_wdata[CB_PAUSE];
      end
      if (reg_wr && reg_addr == W_BURST) burst_q <= reg_wdata[CNTW-1:0];
      if (reg_wr && reg_addr == W_XMIT)  xmit_q  <= reg_wdata[CNTW-1:0];
      if (ctl_wr && reg_wdata[CB_GO] && reg_wdata[CB_EN] && reg_wdata[CB_MASTER] && !go_q) begin
        go_q    <= 1'b1;
        start_q <= 1'b1;
      end else if (done || !run_en) begin
        go_q <= 1'b0;
      end
    end
  end

  spi_bm_fifo #(.W(8), .DEPTH(DEPTH)) tx_fifo_i (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(tx_push), .din(tx_data), .pop(tx_pop),
    .head(tx_head), .count(tx_cnt), .empty(tx_empty)
  );

  spi_bm_fifo #(.W(8), .DEPTH(DEPTH)) rx_fifo_i (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(rx_push), .din(rx_byte), .pop(rx_pop),
    .head(rx_head), .count(rx_cnt), .empty(rx_empty)
  );

  spi_bm_engine #(.CNTW(CNTW)) eng_i (
    .clk(clk), .rst(rst), .en(run_en), .cpol(cpol_q), .cpha(cpha_q),
    .pause(pause_q), .start(start_q), .burst_len(burst_q), .xmit_len(xmit_q),
    .tick(sclk_tick), .tx_empty(tx_empty), .tx_head(tx_head), .miso(miso),
    .busy(busy), .done(done), .tx_pop(tx_pop), .rx_push(rx_push),
    .rx_byte(rx_byte), .sclk(sclk), .mosi(mosi)
  );

  always_ff @(posedge clk) begin
    if (rst)                      rx_data <= '0;
    else if (rx_pop && !rx_empty) rx_data <= rx_head;
  end

  always_comb begin
    rd_nxt = '0;
    case (reg_addr)
      W_CTRL: begin
        rd_nxt[CB_EN]     = en_q;
        rd_nxt[CB_MASTER] = master_q;
        rd_nxt[CB_CPHA]   = cpha_q;
        rd_nxt[CB_CPOL]   = cpol_q;
        rd_nxt[CB_CSLOW]  = cs_low_q;
        rd_nxt[CB_GO]     = go_q;
        rd_nxt[CB_CSSEL +: CSW] = cs_sel_q;
        rd_nxt[CB_CSMAN]  = cs_man_q;
        rd_nxt[CB_CSLVL]  = cs_lvl_q;
        rd_nxt[CB_PAUSE]  = pause_q;
      end
      W_BURST: rd_nxt[CNTW-1:0] = burst_q;
      W_XMIT:  rd_nxt[CNTW-1:0] = xmit_q;
      default: begin
        rd_nxt[RX_CNT_LSB +: CW] = rx_cnt;
        rd_nxt[TX_CNT_LSB +: CW] = tx_cnt;
      end
    endcase
  end

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    always_comb begin
      if (CSW'(i) == cs_sel_q)
        cs_nxt[i] = cs_man_q ? cs_lvl_q : (busy ? ~cs_low_q : cs_low_q);
      else
        cs_nxt[i] = cs_low_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      spi_cs    <= '0;
    end else begin
      reg_rdata <= rd_nxt;
      spi_cs    <= cs_nxt;
    end
  end
endmodule

// File: rtl/spi_bm_chk.sv
module spi_bm_chk #(
  parameter int DEPTH = 64,
  parameter int NCS   = 4,
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int CSW = $clog2(NCS)
) (
  input logic           clk,
  input logic           rst,
  input logic           reg_wr,
  input logic           run_en,
  input logic           cpol_q,
  input logic           sclk,
  input logic           go_q,
  input logic [CW-1:0]  tx_cnt,
  input logic [CW-1:0]  rx_cnt,
  input logic           cs_man_q,
  input logic           cs_lvl_q,
  input logic           cs_low_q,
  input logic [CSW-1:0] cs_sel_q,
  input logic [NCS-1:0] spi_cs
);
  // R12
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (sclk == $past(cpol_q)));

  // R12
  go_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !reg_wr) |=> !go_q);

  // R2
  tx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    tx_cnt <= CW'(DEPTH));

  // R2
  rx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rx_cnt <= CW'(DEPTH));

  // R10
  cs_manual_chk: assert property (@(posedge clk) disable iff (rst)
    cs_man_q |=> (spi_cs[$past(cs_sel_q)] == $past(cs_lvl_q)));

  // R11
  cs_single_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(spi_cs ^ {NCS{$past(cs_low_q)}}) <= 1));
endmodule

bind spi_burst_master spi_bm_chk #(.DEPTH(DEPTH), .NCS(NCS)) chk_i (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .run_en(run_en), .cpol_q(cpol_q),
  .sclk(sclk), .go_q(go_q), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .cs_man_q(cs_man_q), .cs_lvl_q(cs_lvl_q), .cs_low_q(cs_low_q),
  .cs_sel_q(cs_sel_q), .spi_cs(spi_cs)
);

// File: tb/spi_burst_master_tb_top.sv
module spi_burst_master_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_push = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        rx_pop = 1'b0;
  logic [7:0]  rx_data;
  logic        sclk_tick = 1'b0;
  logic        sclk, mosi, miso;
  logic [3:0]  spi_cs;

  int total = 0;
  int bad = 0;

  logic [7:0] mosi_q[$];
  logic [7:0] rx_q[$];
  logic       mon_en = 1'b0;
  logic       mon_cpol = 1'b0;
  logic       mon_cpha = 1'b0;
  int         mon_bits = 0;
  logic [7:0] mon_sh = '0;

  always #2 clk = ~clk;
  always @(posedge clk) sclk_tick <= ~sclk_tick;
  assign miso = ~mosi;

  spi_burst_master dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_push(tx_push),
    .tx_data(tx_data), .rx_pop(rx_pop), .rx_data(rx_data),
    .sclk_tick(sclk_tick), .sclk(sclk), .mosi(mosi), .miso(miso),
    .spi_cs(spi_cs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    tx_push = 1'b1; tx_data = b;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic pop(output logic [7:0] b);
    @(negedge clk);
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
    b = rx_data;
  endtask

  task automatic wait_go_clear();
    logic [31:0] d;
    d = 32'h400;
    while (d[10]) rd(2'd0, d);
  endtask

  // monitor: samples MOSI on the mode's sampling edge, MSB first (R3)
  always @(sclk) begin
    if (mon_en && ((sclk ^ mon_cpol ^ mon_cpha) == 1'b1)) begin
      mon_sh = {mon_sh[6:0], mosi};
      mon_bits++;
      if (mon_bits == 8) begin
        mon_bits = 0;
        if (mosi_q.size() == 0) chk("R3 unexpected byte", {24'h0, mon_sh}, 32'hFFFF_FFFF);
        else chk("R3 mosi byte", {24'h0, mon_sh}, {24'h0, mosi_q.pop_front()});
      end
    end
  end

  // runs one burst; pushes nfill bytes; expects zeros past them (R4 R6 R7)
  task automatic burst(input logic cpol, input logic cpha, input int n, input int tc,
                       input int nfill, input int seed);
    logic [31:0] cfg, d;
    logic [7:0]  b, e;
    cfg = 32'h3 | (32'(cpha) << 2) | (32'(cpol) << 3) | 32'h10 | (32'h1 << 12);
    wr(2'd0, cfg);
    repeat (3) @(negedge clk);
    mon_cpol = cpol; mon_cpha = cpha; mon_bits = 0; mon_en = 1'b1;
    wr(2'd1, 32'(n));
    wr(2'd2, 32'(tc));
    for (int k = 0; k < n; k++) begin
      b = 8'(k * 37 + seed);
      if (k < nfill) begin
        push(b);
        mosi_q.push_back(b);
        rx_q.push_back(~b);
      end else begin
        mosi_q.push_back(8'h00);
        rx_q.push_back(8'hFF);
      end
    end
    wr(2'd0, cfg | 32'h400);
    repeat (6) @(negedge clk);
    chk("R11 auto cs during burst", {28'h0, spi_cs}, 32'hD);
    rd(2'd0, d);
    chk("R4 go bit set while busy", {31'h0, d[10]}, 32'h1);
    wait_go_clear();
    repeat (4) @(negedge clk);
    mon_en = 1'b0;
    chk("R4 all bytes sent", 32'(mosi_q.size()), 32'h0);
    chk("R11 cs released after burst", {28'h0, spi_cs}, 32'hF);
    rd(2'd3, d);
    chk("R5 rx count", {25'h0, d[6:0]}, 32'(n));
    while (rx_q.size() > 0) begin
      e = rx_q.pop_front();
      pop(b);
      chk("R5 rx byte", {24'h0, b}, {24'h0, e});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(2'd0, d);
    chk("R1 ctrl after reset", d, 32'h0);
    rd(2'd3, d);
    chk("R1 status after reset", d, 32'h0);
    chk("R1 sclk after reset", {31'h0, sclk}, 32'h0);
    chk("R1 cs after reset", {28'h0, spi_cs}, 32'h0);

    // R3 R4 R5 all four modes
    burst(1'b0, 1'b0, 5, 5, 5, 3);
    burst(1'b0, 1'b1, 5, 5, 5, 71);
    burst(1'b1, 1'b0, 5, 5, 5, 129);
    burst(1'b1, 1'b1, 5, 5, 5, 200);
    // R6 transmit count shorter than burst
    burst(1'b0, 1'b0, 4, 1, 1, 90);
    // R7 fifo underflow without pause sends zero
    burst(1'b1, 1'b1, 3, 3, 1, 17);
    rd(2'd3, d);
    chk("R7 tx fifo left empty", {25'h0, d[22:16]}, 32'h0);

    // R8 pause on empty fifo
    begin
      logic [31:0] cfg;
      logic [7:0]  b;
      cfg = 32'h3 | 32'h10 | (32'h1 << 12) | (32'h1 << 18);
      wr(2'd0, cfg);
      repeat (3) @(negedge clk);
      mon_cpol = 1'b0; mon_cpha = 1'b0; mon_bits = 0; mon_en = 1'b1;
      wr(2'd1, 32'd2);
      wr(2'd2, 32'd2);
      push(8'hA5); mosi_q.push_back(8'hA5);
      wr(2'd0, cfg | 32'h400);
      repeat (200) @(negedge clk);
      rd(2'd0, d);
      chk("R8 go held during pause", {31'h0, d[10]}, 32'h1);
      chk("R8 sclk idle during pause", {31'h0, sclk}, 32'h0);
      chk("R8 one byte before stall", 32'(mosi_q.size()), 32'h0);
      push(8'h3C); mosi_q.push_back(8'h3C);
      wait_go_clear();
      repeat (4) @(negedge clk);
      mon_en = 1'b0;
      chk("R8 resumed byte sent", 32'(mosi_q.size()), 32'h0);
      pop(b); chk("R8 rx first", {24'h0, b}, 32'h5A);
      pop(b); chk("R8 rx second", {24'h0, b}, 32'hC3);
    end

    // R2 depth limit
    for (int k = 0; k < 70; k++) push(8'(k));
    rd(2'd3, d);
    chk("R2 tx count capped", {25'h0, d[22:16]}, 32'd64);
    chk("R2 rx count zero", {25'h0, d[6:0]}, 32'h0);

    // R12 abort mid-burst
    wr(2'd0, 32'h3 | 32'h8 | 32'h10);
    wr(2'd1, 32'd20);
    wr(2'd2, 32'd20);
    wr(2'd0, 32'h3 | 32'h8 | 32'h10 | 32'h400);
    repeat (100) @(negedge clk);
    wr(2'd0, 32'h8 | 32'h10);
    repeat (3) @(negedge clk);
    rd(2'd0, d);
    chk("R12 go cleared on disable", {31'h0, d[10]}, 32'h0);
    chk("R12 sclk idle high", {31'h0, sclk}, 32'h1);
    rd(2'd3, d);
    chk("R12 rx holds partial bytes", {31'h0, (d[6:0] != 0)}, 32'h1);

    // R9 flushes, one at a time
    wr(2'd0, 32'h10 | 32'h100);
    rd(2'd3, d);
    chk("R9 tx flushed", {25'h0, d[22:16]}, 32'h0);
    chk("R9 rx untouched by tx flush", {31'h0, (d[6:0] != 0)}, 32'h1);
    wr(2'd0, 32'h10 | 32'h200);
    rd(2'd3, d);
    chk("R9 rx flushed", d, 32'h0);

    // R10 manual chip select
    wr(2'd0, 32'h10 | (32'h2 << 12) | (32'h1 << 16));
    repeat (2) @(negedge clk);
    chk("R10 manual assert low", {28'h0, spi_cs}, 32'hB);
    wr(2'd0, 32'h10 | (32'h2 << 12) | (32'h1 << 16) | (32'h1 << 17));
    repeat (2) @(negedge clk);
    chk("R10 manual release", {28'h0, spi_cs}, 32'hF);
    wr(2'd0, (32'h3 << 12) | (32'h1 << 16) | (32'h1 << 17));
    repeat (2) @(negedge clk);
    chk("R10 active-high select", {28'h0, spi_cs}, 32'h8);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule